// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction fetch address of a small 8-bit core and the hardware return stack that goes with it. The address is 14 bits wide and covers 16K instruction words. It is seen as sixteen pages of 1K words: the upper four bits select the page and the lower ten bits give the offset inside it. Each clock is one instruction cycle. In every cycle the block takes the decoded operation and its operands (a 10-bit immediate, the 8-bit accumulator and a 4-bit page-select value) and forms the next fetch address.

Control transfers come in three groups. Immediate jumps and calls replace the offset and take the page from the page-select input. Return operations take their address from the stack. Three accumulator-based writes differ in how they treat offset bits 9:8. A move clears them and so does an add, but a table lookup keeps them, together with the page, from the incremented address. An interrupt request is a single input. It overrides the decoded operation, saves the address of the instruction it displaces and jumps to a fixed vector.

The stack is an eight-entry ring with no overflow or underflow reporting. A ninth call overwrites the oldest saved address. A return with nothing saved reads whatever entry the pointer wraps onto.

Top module: `paged_pc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `fetch_pc` to 0x0000 on the following cycle, clears every stack entry to 0x0000 and empties the stack.
- R2: Operation code 0 (step), and also the unused code 7, set the next `fetch_pc` to the current value plus one, wrapping from 0x3FFF to 0x0000.
- R3: Operation code 1 (jump) sets the next `fetch_pc` to `{page_sel, imm_addr}`: page in bits 13:10, immediate in bits 9:0.
- R4: Operation code 2 (call) loads `{page_sel, imm_addr}` like a jump and saves the current `fetch_pc` plus one (wrapping) on the stack. Operation code 3 (return, shared by all return flavours) loads the most recently saved address and removes it.
- R5: Eight nested calls followed by eight returns bring back the eight saved addresses in reverse order of saving.
- R6: The stack holds 8 entries as a ring. After nine calls without a return, the first saved address is lost: the next eight returns give the 9th down to the 2nd saved address, and a further return gives the 9th again.
- R7: A return with an empty stack raises no error and loads the entry the ring pointer wraps onto. Right after reset this is 0x0000.
- R8: Operation code 4 (move accumulator) sets the next `fetch_pc` to `{page_sel, 2'b00, acc_val}`.
- R9: Operation code 5 (add accumulator) sets the next `fetch_pc` to `{page_sel, 2'b00, s}`. Here s = (low 8 bits of `fetch_pc`+1) + `acc_val`, modulo 256, and the carry out is dropped.
- R10: Operation code 6 (table) sets the next `fetch_pc` to `{b, s}`, with s as in R9 and b = bits 13:8 of `fetch_pc`+1. `page_sel` has no effect on it.
- R11: When `irq_take` is high, the decoded operation is ignored. The current `fetch_pc` is saved on the stack and the next `fetch_pc` is the vector 0x0008. A later return resumes at the saved address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 3 | Decoded control operation (codes in R2 to R10) |
| irq_take | input | 1 | Interrupt entry: push current address, load vector |
| imm_addr | input | 10 | Immediate offset for jump and call |
| acc_val | input | 8 | Accumulator value for move, add and table |
| page_sel | input | 4 | Page-select field for the upper address bits |
| fetch_pc | output | 14 | Current instruction fetch address |

## Verification
The bound checker checks, on every cycle, the address-forming rules that depend only on the previous cycle's inputs and address. These are the increment, the jump load, the move with cleared bits 9:8, the page-select source for adds, the upper bits kept by a table lookup, the interrupt vector and the reset value. The stack is not checked cycle by cycle. Last-in-first-out order, the loss of the oldest entry on a ninth call, stale reads on an empty stack and interrupt return addresses are only visible across sequences of operations. The bench's directed scenarios and its random run against a ring-stack model cover these.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;

    typedef enum logic [2:0] {
        PC_STEP = 3'd0,
        PC_JMP  = 3'd1,
        PC_CALL = 3'd2,
        PC_RET  = 3'd3,
        PC_MOVA = 3'd4,
        PC_ADDA = 3'd5,
        PC_TBL  = 3'd6,
        PC_RSVD = 3'd7
    } pc_op_e;

endpackage

// File: rtl/paged_pc_ring.sv
module paged_pc_ring #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] slot;
        logic [PTR_W-1:0]            ptr;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [PTR_W-1:0] ptr_up, ptr_dn;

    // Pointer arithmetic wraps explicitly so any depth forms a ring
    always_comb begin
        ptr_up = (ring_q.ptr == LAST) ? '0 : ring_q.ptr + 1'b1;
        ptr_dn = (ring_q.ptr == '0) ? LAST : ring_q.ptr - 1'b1;
    end

    assign top_data = ring_q.slot[ptr_dn];

    always_comb begin
        ring_d = ring_q;
        if (push) begin
            ring_d.slot[ring_q.ptr] = push_data;
            ring_d.ptr              = ptr_up;
        end else if (pop) begin
            ring_d.ptr = ptr_dn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= ring_d;
    end
endmodule

// File: rtl/paged_pc_target.sv
module paged_pc_target
    import paged_pc_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 10,
    parameter int DATA_W = 8,
    parameter logic [PAGE_W+OFF_W-1:0] VECTOR = 14'h0008
) (
    input  pc_op_e                   op,
    input  logic                     irq,
    input  logic [PAGE_W+OFF_W-1:0]  pc_cur,
    input  logic [OFF_W-1:0]         imm,
    input  logic [DATA_W-1:0]        acc,
    input  logic [PAGE_W-1:0]        page,
    input  logic [PAGE_W+OFF_W-1:0]  pop_data,
    output logic [PAGE_W+OFF_W-1:0]  target,
    output logic                     push,
    output logic                     pop,
    output logic [PAGE_W+OFF_W-1:0]  push_data
);
    localparam int PC_W = PAGE_W + OFF_W;
    localparam int GAP  = OFF_W - DATA_W;

    logic [PC_W-1:0]   seq;
    logic [DATA_W-1:0] sum;

    always_comb begin
        seq = pc_cur + 1'b1;
        sum = seq[DATA_W-1:0] + acc;

        target    = seq;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = seq;

        if (irq) begin
            target    = VECTOR;
            push      = 1'b1;
            push_data = pc_cur;
        end else begin
            unique case (op)
                PC_JMP:  target = {page, imm};
                PC_CALL: begin
                    target = {page, imm};
                    push   = 1'b1;
                end
                PC_RET: begin
                    target = pop_data;
                    pop    = 1'b1;
                end
                PC_MOVA: target = {page, {GAP{1'b0}}, acc};
                PC_ADDA: target = {page, {GAP{1'b0}}, sum};
                PC_TBL:  target = {seq[PC_W-1:DATA_W], sum};
                default: target = seq;
            endcase
        end
    end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import paged_pc_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 10,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter logic [PAGE_W+OFF_W-1:0] VECTOR = 14'h0008
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              op_code,
    input  logic                    irq_take,
    input  logic [OFF_W-1:0]        imm_addr,
    input  logic [DATA_W-1:0]       acc_val,
    input  logic [PAGE_W-1:0]       page_sel,
    output logic [PAGE_W+OFF_W-1:0] fetch_pc
);
    localparam int PC_W = PAGE_W + OFF_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t state_d, state_q;

    logic            stk_push, stk_pop;
    logic [PC_W-1:0] stk_wdata, stk_top, target;

    paged_pc_target #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .VECTOR(VECTOR)
    ) u_target (
        .op        (pc_op_e'(op_code)),
        .irq       (irq_take),
        .pc_cur    (state_q.pc),
        .imm       (imm_addr),
        .acc       (acc_val),
        .page      (page_sel),
        .pop_data  (stk_top),
        .target    (target),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_wdata)
    );

    paged_pc_ring #(
        .DEPTH(DEPTH), .WIDTH(PC_W)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_wdata),
        .top_data  (stk_top)
    );

    always_comb begin
        state_d    = state_q;
        state_d.pc = target;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign fetch_pc = state_q.pc;
endmodule

// File: rtl/paged_pc_checker.sv
module paged_pc_checker
    import paged_pc_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 10,
    parameter int DATA_W = 8,
    parameter logic [PAGE_W+OFF_W-1:0] VECTOR = 14'h0008
) (
    input logic                    clk,
    input logic                    rst,
    input logic [2:0]              op_code,
    input logic                    irq_take,
    input logic [OFF_W-1:0]        imm_addr,
    input logic [DATA_W-1:0]       acc_val,
    input logic [PAGE_W-1:0]       page_sel,
    input logic [PAGE_W+OFF_W-1:0] fetch_pc
);
    localparam int PC_W = PAGE_W + OFF_W;
    localparam int GAP  = OFF_W - DATA_W;

    logic [PC_W-1:0] pc_plus;
    assign pc_plus = fetch_pc + 1'b1;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> fetch_pc == '0); // R1

    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && (op_code == PC_STEP || op_code == PC_RSVD))
        |=> fetch_pc == $past(pc_plus)); // R2

    AST_JMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && op_code == PC_JMP)
        |=> fetch_pc == {$past(page_sel), $past(imm_addr)}); // R3

    AST_MOV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && op_code == PC_MOVA)
        |=> fetch_pc == {$past(page_sel), {GAP{1'b0}}, $past(acc_val)}); // R8

    AST_ADD_PAGE: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && op_code == PC_ADDA)
        |=> fetch_pc[PC_W-1:DATA_W] == {$past(page_sel), {GAP{1'b0}}}); // R9

    AST_TBL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && op_code == PC_TBL)
        |=> fetch_pc[PC_W-1:DATA_W] == $past(pc_plus[PC_W-1:DATA_W])); // R10

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> fetch_pc == VECTOR); // R11
endmodule

bind paged_pc_unit paged_pc_checker #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .VECTOR(VECTOR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .irq_take (irq_take),
    .imm_addr (imm_addr),
    .acc_val  (acc_val),
    .page_sel (page_sel),
    .fetch_pc (fetch_pc)
);

// File: tb/paged_pc_unit_bench.sv
`timescale 1ns/1ps
module paged_pc_unit_bench;
    localparam int OP_STEP = 0, OP_JMP = 1, OP_CALL = 2, OP_RET = 3;
    localparam int OP_MOVA = 4, OP_ADDA = 5, OP_TBL = 6, OP_RSVD = 7;
    localparam logic [13:0] VEC = 14'h0008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = '0;
    logic        irq_take = 1'b0;
    logic [9:0]  imm_addr = '0;
    logic [7:0]  acc_val = '0;
    logic [3:0]  page_sel = '0;
    logic [13:0] fetch_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [13:0] exp_pc;
    logic [13:0] mstk [8];
    int          msp;

    always #10 clk = ~clk;

    paged_pc_unit u_paged_pc_unit (
        .clk(clk), .rst(rst), .op_code(op_code), .irq_take(irq_take),
        .imm_addr(imm_addr), .acc_val(acc_val), .page_sel(page_sel),
        .fetch_pc(fetch_pc)
    );

    function automatic string tag_of(int op, bit ir);
        if (ir) return "R11";
        case (op)
            OP_JMP:  return "R3";
            OP_CALL, OP_RET: return "R4";
            OP_MOVA: return "R8";
            OP_ADDA: return "R9";
            OP_TBL:  return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input logic [13:0] act, input logic [13:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: fetch_pc actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mpush(input logic [13:0] v);
        mstk[msp] = v;
        msp = (msp + 1) % 8;
    endtask

    task automatic mpop(output logic [13:0] v);
        msp = (msp + 7) % 8;
        v = mstk[msp];
    endtask

    // Called at a falling edge: drive, predict, wait one cycle, compare
    task automatic step(input int op, input logic [9:0] im, input logic [7:0] a,
                        input logic [3:0] pg, input bit ir, input string tag);
        logic [13:0] seq, nxt;
        logic [7:0]  s;
        op_code = 3'(op); imm_addr = im; acc_val = a; page_sel = pg; irq_take = ir;
        seq = exp_pc + 14'd1;
        s = seq[7:0] + a;
        if (ir) begin
            mpush(exp_pc);
            nxt = VEC;
        end else begin
            case (op)
                OP_JMP:  nxt = {pg, im};
                OP_CALL: begin mpush(seq); nxt = {pg, im}; end
                OP_RET:  mpop(nxt);
                OP_MOVA: nxt = {pg, 2'b00, a};
                OP_ADDA: nxt = {pg, 2'b00, s};
                OP_TBL:  nxt = {seq[13:8], s};
                default: nxt = seq;
            endcase
        end
        exp_pc = nxt;
        @(negedge clk);
        check(fetch_pc, exp_pc, (tag == "") ? tag_of(op, ir) : tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; op_code = '0; irq_take = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_pc = '0; msp = 0;
        foreach (mstk[i]) mstk[i] = '0;
        check(fetch_pc, 14'h0000, "R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        exp_pc = '0; msp = 0;
        @(negedge clk);
        do_reset();

        // R7: return on empty stack right after reset reads a cleared entry
        step(OP_RET, 10'h0, 8'h0, 4'h0, 0, "R7");
        step(OP_RET, 10'h0, 8'h0, 4'h0, 0, "R7");
        do_reset();

        // R3 / R2: jump to the top address, then wrap, then unused code
        step(OP_JMP, 10'h3FF, 8'h00, 4'hF, 0, "R3");
        step(OP_STEP, 10'h0, 8'h0, 4'h0, 0, "R2");
        step(OP_RSVD, 10'h155, 8'hAA, 4'h7, 0, "R2");

        // R5: eight nested calls, then eight returns
        for (int k = 0; k < 8; k++)
            step(OP_CALL, 10'(k * 37 + 5), 8'h0, 4'(k + 1), 0, "R4");
        for (int k = 0; k < 8; k++)
            step(OP_RET, 10'h0, 8'h0, 4'h0, 0, "R5");

        // R6: nine calls overwrite the oldest entry, nine returns
        do_reset();
        for (int k = 0; k < 9; k++)
            step(OP_CALL, 10'(k * 91 + 3), 8'h0, 4'(k), 0, "R4");
        for (int k = 0; k < 9; k++)
            step(OP_RET, 10'h0, 8'h0, 4'h0, 0, "R6");
        // R7: further pops keep wrapping round the ring
        step(OP_RET, 10'h0, 8'h0, 4'h0, 0, "R7");

        // R8: move clears bits 9:8
        step(OP_JMP, 10'h3C0, 8'h0, 4'h1, 0, "R3");
        step(OP_MOVA, 10'h3FF, 8'hFF, 4'h5, 0, "R8");
        // R9: add drops the carry and clears bits 9:8
        step(OP_MOVA, 10'h0, 8'hF0, 4'h2, 0, "R8");
        step(OP_ADDA, 10'h0, 8'h20, 4'h2, 0, "R9");
        // R10: table keeps upper bits of pc+1, ignores page_sel
        step(OP_JMP, 10'h2FE, 8'h0, 4'h3, 0, "R3");
        step(OP_TBL, 10'h0, 8'h05, 4'h9, 0, "R10");
        step(OP_JMP, 10'h1FF, 8'h0, 4'h6, 0, "R3");
        step(OP_TBL, 10'h0, 8'h00, 4'hA, 0, "R10");

        // R11: interrupt overrides a call, return resumes at the displaced address
        step(OP_JMP, 10'h123, 8'h0, 4'h4, 0, "R3");
        step(OP_CALL, 10'h3AA, 8'h0, 4'hE, 1, "R11");
        step(OP_STEP, 10'h0, 8'h0, 4'h0, 0, "R2");
        step(OP_RET, 10'h0, 8'h0, 4'h0, 0, "R11");

        // Random mix of all operations
        for (int n = 0; n < 4000; n++) begin
            int op;
            bit ir;
            op = int'($urandom_range(0, 7));
            ir = ($urandom_range(0, 15) == 0);
            step(op, 10'($urandom), 8'($urandom), 4'($urandom), ir, "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule